// File: doc/BRIEF.md
# Two-Slot Transmit Frame Request Queue

This block is the register-facing front end of an Ethernet MAC transmitter. Software describes each outgoing frame with two writes: first the buffer start address, then a control word holding the byte length and a flag saying that the buffer already carries its own CRC. The block holds at most two such frames. One is the frame the transmit engine is working on, and the other waits behind it. When a frame starts, the block sends a one-cycle start pulse together with that frame's address, length and flags to the DMA/transmit engine.

The engine reports back through event strobes: frame finished, collision seen, retry limit reached and data underrun. The block turns these into sticky status flags that software clears by writing ones. While an underrun has hit the current frame, the block drives a bad-CRC command. Two level outputs show whether a slot is free and whether the queue is completely idle. A write made while both slots are full is not accepted. It raises a sticky overrun flag and leaves the queue as it was.

Top module: `tx_frame_queue`

## Requirements
- R1: After synchronous reset, `q_idle`=1, `q_free`=1, `tx_start`=0, `tx_bad_crc`=0 and all sticky flags are 0, so a status read returns 0x3.
- R2: Register index 0 stages the buffer address. A write to index 1 (length in bits 10:0, no-CRC flag in bit 15) with a non-zero length, made while no frame is in progress, causes `tx_start` to pulse for one cycle after the write edge. In that cycle `tx_addr`, `tx_len` and `tx_nocrc` carry the staged address and the written fields.
- R3: A write to index 1 with length zero queues nothing and starts nothing.
- R4: A valid length written while one frame is in progress is held in the second slot. `q_free` is 0 exactly while both slots are occupied.
- R5: When `ev_done` arrives with a frame waiting, the waiting frame becomes current in the same edge, and `tx_start` pulses in the following cycle with its descriptor. Without a waiting frame, `ev_done` empties the queue. `ev_done` is ignored when no frame is in progress.
- R6: A write to index 0 or 1 while `q_free`=0 sets the sticky overrun flag (status bit 2). The write is discarded: neither the staged address nor either slot changes.
- R7: The status flags overrun (bit 2), collision (bit 3), retry limit (bit 4), complete (bit 5) and underrun (bit 6) are sticky. They are set by their event (`ev_col`, `ev_retry`, a finishing `ev_done`, `ev_under`) and cleared by writing a one to their bit at index 2. A set in the same cycle wins over a clear.
- R8: `q_idle` (status bit 0) is 1 exactly when neither slot holds a frame. It falls in the cycle after an accepted length write.
- R9: `ev_under` while a frame is in progress makes `tx_bad_crc` 1 from the next cycle until that frame finishes.
- R10: A read of index 1 returns the full length and no-CRC flag of the current frame, unchanged while it is sent. A read of index 0 returns the staged address. A read of index 2 returns the status word. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R11: A frame longer than 1514 bytes (1518 with the no-CRC flag) is still started, with `tx_oversize`=1 alongside its descriptor. Otherwise `tx_oversize` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 2 | Register index: 0 address, 1 control, 2 status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after `reg_rd` |
| ev_done | input | 1 | Engine finished the current frame |
| ev_col | input | 1 | Engine saw a collision |
| ev_retry | input | 1 | Engine hit its retry limit |
| ev_under | input | 1 | Engine ran out of data in time |
| tx_start | output | 1 | One-cycle start pulse for the current frame |
| tx_addr | output | AW | Buffer address of the current frame |
| tx_len | output | LW | Byte length of the current frame |
| tx_nocrc | output | 1 | Current frame carries its own CRC |
| tx_oversize | output | 1 | Current frame exceeds the normal size limit |
| tx_bad_crc | output | 1 | Engine must corrupt the CRC of the current frame |
| q_free | output | 1 | A slot is available for a new frame |
| q_idle | output | 1 | No frame is held |

## Verification
The bound checker watches several properties on every cycle. An idle queue always reports a free slot, and every start pulse comes with a non-idle queue. A write into a full queue sets overrun and leaves the current descriptor and start line untouched. A done with a waiting frame always produces a start in the next cycle. Collision and underrun events always leave their flags or bad-CRC command set. Only the bench's scenarios can show the rest, by comparing against a reference model across directed and random traffic: that the promoted frame carries the earlier descriptor and not a discarded one, that length readback stays fixed, the oversize thresholds with and without the no-CRC flag, zero-length writes, and write-one-to-clear races.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // register indices
  localparam logic [1:0] RI_ADDR = 2'd0;
  localparam logic [1:0] RI_CTRL = 2'd1;
  localparam logic [1:0] RI_STAT = 2'd2;

  // control word layout
  localparam int NCRC_BIT = 15;

  // status word layout
  localparam int ST_IDLE   = 0;
  localparam int ST_FREE   = 1;
  localparam int FLAG_BASE = 2;

  // sticky flag order inside the flag vector
  localparam int FL_OVR = 0;
  localparam int FL_COL = 1;
  localparam int FL_RTY = 2;
  localparam int FL_CMP = 3;
  localparam int FL_UND = 4;
  localparam int FL_N   = 5;
endpackage

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_o[k] <= 1'b0;
      else if (set_i[k])
        flag_o[k] <= 1'b1;
      else if (clr_i[k])
        flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_slots.sv
module txq_slots #(
  parameter int AW      = 32,
  parameter int LW      = 11,
  parameter int MAX_PAY = 1514,
  parameter int CRC_B   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          done_i,
  input  logic [AW-1:0] new_addr_i,
  input  logic [LW-1:0] new_len_i,
  input  logic          new_ncrc_i,
  output logic          act_v_o,
  output logic          pend_v_o,
  output logic          start_o,
  output logic [AW-1:0] act_addr_o,
  output logic [LW-1:0] act_len_o,
  output logic          act_ncrc_o,
  output logic          act_ovs_o
);
  localparam logic [LW-1:0] LIM_CRC  = LW'(MAX_PAY);
  localparam logic [LW-1:0] LIM_NCRC = LW'(MAX_PAY + CRC_B);

  logic [AW-1:0] pnd_addr;
  logic [LW-1:0] pnd_len;
  logic          pnd_ncrc;
  logic          fin;

  function automatic logic oversize(input logic [LW-1:0] l, input logic n);
    return n ? (l > LIM_NCRC) : (l > LIM_CRC);
  endfunction

  assign fin = done_i && act_v_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_v_o    <= 1'b0;
      pend_v_o   <= 1'b0;
      start_o    <= 1'b0;
      act_addr_o <= '0;
      act_len_o  <= '0;
      act_ncrc_o <= 1'b0;
      act_ovs_o  <= 1'b0;
      pnd_addr   <= '0;
      pnd_len    <= '0;
      pnd_ncrc   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (fin || !act_v_o) begin
        if (pend_v_o) begin
          act_v_o    <= 1'b1;
          start_o    <= 1'b1;
          act_addr_o <= pnd_addr;
          act_len_o  <= pnd_len;
          act_ncrc_o <= pnd_ncrc;
          act_ovs_o  <= oversize(pnd_len, pnd_ncrc);
          pend_v_o   <= accept_i;
          if (accept_i) begin
            pnd_addr <= new_addr_i;
            pnd_len  <= new_len_i;
            pnd_ncrc <= new_ncrc_i;
          end
        end else if (accept_i) begin
          act_v_o    <= 1'b1;
          start_o    <= 1'b1;
          act_addr_o <= new_addr_i;
          act_len_o  <= new_len_i;
          act_ncrc_o <= new_ncrc_i;
          act_ovs_o  <= oversize(new_len_i, new_ncrc_i);
        end else begin
          act_v_o <= 1'b0;
        end
      end else if (accept_i) begin
        pend_v_o <= 1'b1;
        pnd_addr <= new_addr_i;
        pnd_len  <= new_len_i;
        pnd_ncrc <= new_ncrc_i;
      end
    end
  end
endmodule

// File: rtl/tx_frame_queue.sv
module tx_frame_queue
  import txq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LW      = 11,
  parameter int MAX_PAY = 1514,
  parameter int CRC_B   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_done,
  input  logic          ev_col,
  input  logic          ev_retry,
  input  logic          ev_under,
  output logic          tx_start,
  output logic [AW-1:0] tx_addr,
  output logic [LW-1:0] tx_len,
  output logic          tx_nocrc,
  output logic          tx_oversize,
  output logic          tx_bad_crc,
  output logic          q_free,
  output logic          q_idle
);
  logic [AW-1:0]   stage_q;
  logic [FL_N-1:0] sticky_q, f_set, f_clr;
  logic            act_v, pend_v, fin;
  logic            wr_a, wr_c, wr_s, accept;
  logic [LW-1:0]   w_len;
  logic            w_ncrc;

  assign wr_a   = reg_wr && (reg_idx == RI_ADDR);
  assign wr_c   = reg_wr && (reg_idx == RI_CTRL);
  assign wr_s   = reg_wr && (reg_idx == RI_STAT);
  assign w_len  = reg_wdata[LW-1:0];
  assign w_ncrc = reg_wdata[NCRC_BIT];
  assign q_free = !(act_v && pend_v);
  assign q_idle = !act_v && !pend_v;
  assign fin    = ev_done && act_v;
  assign accept = wr_c && q_free && (w_len != '0);

  always_ff @(posedge clk) begin
    if (rst)
      stage_q <= '0;
    else if (wr_a && q_free)
      stage_q <= reg_wdata[AW-1:0];
  end

  always_comb begin
    f_set         = '0;
    f_set[FL_OVR] = (wr_a || wr_c) && !q_free;
    f_set[FL_COL] = ev_col;
    f_set[FL_RTY] = ev_retry;
    f_set[FL_CMP] = fin;
    f_set[FL_UND] = ev_under;
    f_clr         = wr_s ? reg_wdata[FLAG_BASE +: FL_N] : '0;
  end

  txq_flags #(.N(FL_N)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (f_set),
    .clr_i  (f_clr),
    .flag_o (sticky_q)
  );

  txq_slots #(.AW(AW), .LW(LW), .MAX_PAY(MAX_PAY), .CRC_B(CRC_B)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .done_i     (ev_done),
    .new_addr_i (stage_q),
    .new_len_i  (w_len),
    .new_ncrc_i (w_ncrc),
    .act_v_o    (act_v),
    .pend_v_o   (pend_v),
    .start_o    (tx_start),
    .act_addr_o (tx_addr),
    .act_len_o  (tx_len),
    .act_ncrc_o (tx_nocrc),
    .act_ovs_o  (tx_oversize)
  );

  always_ff @(posedge clk) begin
    if (rst)
      tx_bad_crc <= 1'b0;
    else if (fin)
      tx_bad_crc <= 1'b0;
    else if (ev_under && act_v)
      tx_bad_crc <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_idx)
        RI_ADDR: reg_rdata[AW-1:0] <= stage_q;
        RI_CTRL: begin
          reg_rdata[LW-1:0]     <= tx_len;
          reg_rdata[NCRC_BIT]   <= tx_nocrc;
        end
        RI_STAT: begin
          reg_rdata[ST_IDLE]            <= q_idle;
          reg_rdata[ST_FREE]            <= q_free;
          reg_rdata[FLAG_BASE +: FL_N]  <= sticky_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [1:0]    reg_idx,
  input logic          ev_done,
  input logic          ev_col,
  input logic          ev_under,
  input logic          tx_start,
  input logic [AW-1:0] tx_addr,
  input logic          tx_bad_crc,
  input logic          q_free,
  input logic          q_idle,
  input logic [4:0]    sticky
);
  // R8
  idle_implies_free_chk: assert property (@(posedge clk) disable iff (rst)
    q_idle |-> q_free);

  // R2
  start_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !q_idle);

  // R6
  overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_idx == 2'd0 || reg_idx == 2'd1) && !q_free) |=> sticky[0]);

  // R6
  overrun_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_idx == 2'd1 && !q_free && !ev_done) |=> ($stable(tx_addr) && !tx_start));

  // R5
  promote_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_done && !q_free) |=> tx_start);

  // R7
  collision_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ev_col |=> sticky[1]);

  // R9
  bad_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_under && !q_idle && !ev_done) |=> tx_bad_crc);
endmodule

bind tx_frame_queue txq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_idx    (reg_idx),
  .ev_done    (ev_done),
  .ev_col     (ev_col),
  .ev_under   (ev_under),
  .tx_start   (tx_start),
  .tx_addr    (tx_addr),
  .tx_bad_crc (tx_bad_crc),
  .q_free     (q_free),
  .q_idle     (q_idle),
  .sticky     (sticky_q)
);

// File: tb/sim_tx_frame_queue.sv
module sim_tx_frame_queue;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ev_done, ev_col, ev_retry, ev_under;
  logic        tx_start, tx_nocrc, tx_oversize, tx_bad_crc, q_free, q_idle;
  logic [31:0] tx_addr;
  logic [10:0] tx_len;

  always #4 clk = ~clk;

  tx_frame_queue u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
    .ev_col(ev_col), .ev_retry(ev_retry), .ev_under(ev_under),
    .tx_start(tx_start), .tx_addr(tx_addr), .tx_len(tx_len),
    .tx_nocrc(tx_nocrc), .tx_oversize(tx_oversize), .tx_bad_crc(tx_bad_crc),
    .q_free(q_free), .q_idle(q_idle)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  bit          m_av, m_pv, m_start, m_bad, m_rv;
  logic [31:0] m_aa, m_pa, m_stage, m_rexp;
  logic [10:0] m_al, m_pl;
  bit          m_an, m_pn;
  logic [4:0]  m_fl;

  function automatic bit exp_ovs(input logic [10:0] l, input bit n);
    return n ? (l > 11'd1518) : (l > 11'd1514);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [10:0] l, input bit n);
    return {16'd0, n, 4'd0, l};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    reg_wr = 0; reg_rd = 0; reg_idx = 0; reg_wdata = 0;
    ev_done = 0; ev_col = 0; ev_retry = 0; ev_under = 0;
  endtask

  task automatic model_reset();
    m_av = 0; m_pv = 0; m_start = 0; m_bad = 0; m_rv = 0;
    m_aa = 0; m_pa = 0; m_stage = 0; m_rexp = 0;
    m_al = 0; m_pl = 0; m_an = 0; m_pn = 0; m_fl = 0;
  endtask

  task automatic tick();
    bit free, fin, wa, wc, ws, acc;
    logic [4:0] setv, clrv;
    @(posedge clk);
    free = !(m_av && m_pv);
    fin  = ev_done && m_av;
    wa   = reg_wr && reg_idx == 2'd0;
    wc   = reg_wr && reg_idx == 2'd1;
    ws   = reg_wr && reg_idx == 2'd2;
    acc  = wc && free && (reg_wdata[10:0] != 0);
    m_rv = reg_rd;
    if (reg_rd) begin
      case (reg_idx)
        2'd0: m_rexp = m_stage;
        2'd1: m_rexp = ctrl_word(m_al, m_an);
        2'd2: m_rexp = {25'd0, m_fl, free, !m_av && !m_pv};
        default: m_rexp = 0;
      endcase
    end
    setv = {ev_under, fin, ev_retry, ev_col, (wa || wc) && !free};
    clrv = ws ? reg_wdata[6:2] : 5'd0;
    m_fl = (m_fl & ~clrv) | setv;
    if (fin) m_bad = 0;
    else if (ev_under && m_av) m_bad = 1;
    m_start = 0;
    if (fin || !m_av) begin
      if (m_pv) begin
        m_av = 1; m_start = 1; m_aa = m_pa; m_al = m_pl; m_an = m_pn;
        m_pv = acc;
        if (acc) begin m_pa = m_stage; m_pl = reg_wdata[10:0]; m_pn = reg_wdata[15]; end
      end else if (acc) begin
        m_av = 1; m_start = 1; m_aa = m_stage; m_al = reg_wdata[10:0]; m_an = reg_wdata[15];
      end else m_av = 0;
    end else if (acc) begin
      m_pv = 1; m_pa = m_stage; m_pl = reg_wdata[10:0]; m_pn = reg_wdata[15];
    end
    if (wa && free) m_stage = reg_wdata;
    @(negedge clk);
    chk("R2 start pulse", {31'd0, tx_start}, {31'd0, m_start});
    chk("R4 free", {31'd0, q_free}, {31'd0, !(m_av && m_pv)});
    chk("R8 idle", {31'd0, q_idle}, {31'd0, !m_av && !m_pv});
    chk("R9 bad crc", {31'd0, tx_bad_crc}, {31'd0, m_bad});
    if (m_start) begin
      chk("R5 descriptor addr", tx_addr, m_aa);
      chk("R2 descriptor len", {21'd0, tx_len}, {21'd0, m_al});
      chk("R2 descriptor nocrc", {31'd0, tx_nocrc}, {31'd0, m_an});
      chk("R11 oversize", {31'd0, tx_oversize}, {31'd0, exp_ovs(m_al, m_an)});
    end
    if (m_rv) chk("R10 read data", reg_rdata, m_rexp);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    quiet(); reg_wr = 1; reg_idx = idx; reg_wdata = d; tick(); quiet();
  endtask

  task automatic rd(input logic [1:0] idx);
    quiet(); reg_rd = 1; reg_idx = idx; tick(); quiet();
  endtask

  task automatic pulse_done();
    quiet(); ev_done = 1; tick(); quiet();
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    quiet();
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 idle", {31'd0, q_idle}, 32'd1);
    chk("R1 free", {31'd0, q_free}, 32'd1);
    chk("R1 start", {31'd0, tx_start}, 32'd0);
    chk("R1 bad crc", {31'd0, tx_bad_crc}, 32'd0);
    rd(2'd2);
    chk("R1 status", reg_rdata, 32'h3);

    // R3 zero length
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, ctrl_word(11'd0, 1'b0));
    chk("R3 zero length keeps idle", {31'd0, q_idle}, 32'd1);

    // R2 first frame
    wr(2'd1, ctrl_word(11'd60, 1'b0));
    chk("R2 start after length", {31'd0, tx_start}, 32'd1);
    chk("R8 idle falls", {31'd0, q_idle}, 32'd0);

    // R4 second frame queued
    wr(2'd0, 32'h2000_0040);
    wr(2'd1, ctrl_word(11'd100, 1'b1));
    chk("R4 queue full", {31'd0, q_free}, 32'd0);

    // R6 overrun on both registers
    wr(2'd0, 32'h3333_0000);
    wr(2'd1, ctrl_word(11'd77, 1'b0));
    rd(2'd2);
    chk("R6 overrun flag", {31'd0, reg_rdata[2]}, 32'd1);
    rd(2'd0);
    chk("R6 staged addr kept", reg_rdata, 32'h2000_0040);

    // R10 readback
    rd(2'd1);
    chk("R10 length readback", reg_rdata, ctrl_word(11'd60, 1'b0));

    // R9 underrun
    quiet(); ev_under = 1; tick(); quiet();
    tick();
    chk("R9 bad crc held", {31'd0, tx_bad_crc}, 32'd1);

    // R5 promotion
    pulse_done();
    chk("R5 promoted start", {31'd0, tx_start}, 32'd1);
    chk("R6 discarded write not sent", tx_addr, 32'h2000_0040);
    chk("R9 bad crc cleared", {31'd0, tx_bad_crc}, 32'd0);

    // R7 clear flags
    wr(2'd2, 32'h7C);
    rd(2'd2);
    chk("R7 flags cleared", {27'd0, reg_rdata[6:2]}, 32'd0);
    // R7 set wins over clear
    quiet(); ev_col = 1; reg_wr = 1; reg_idx = 2'd2; reg_wdata = 32'h08; tick(); quiet();
    rd(2'd2);
    chk("R7 set beats clear", {31'd0, reg_rdata[3]}, 32'd1);
    pulse_done();
    chk("R5 done empties", {31'd0, q_idle}, 32'd1);
    pulse_done();
    chk("R5 done ignored when empty", {31'd0, q_idle}, 32'd1);

    // R11 oversize thresholds
    wr(2'd1, ctrl_word(11'd1515, 1'b0));
    chk("R11 1515 with crc oversize", {31'd0, tx_oversize}, 32'd1);
    pulse_done();
    wr(2'd1, ctrl_word(11'd1518, 1'b1));
    chk("R11 1518 no crc normal", {31'd0, tx_oversize}, 32'd0);
    pulse_done();
    wr(2'd1, ctrl_word(11'd1514, 1'b0));
    chk("R11 1514 with crc normal", {31'd0, tx_oversize}, 32'd0);
    pulse_done();

    // random traffic, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      quiet();
      r = int'($urandom % 16);
      if (r < 3) begin
        reg_wr = 1; reg_idx = 2'd0; reg_wdata = $urandom;
      end else if (r < 6) begin
        reg_wr = 1; reg_idx = 2'd1;
        reg_wdata = ctrl_word(($urandom % 8 == 0) ? 11'd0 : 11'($urandom), 1'($urandom));
      end else if (r == 6) begin
        reg_wr = 1; reg_idx = 2'd2; reg_wdata = $urandom;
      end else if (r < 10) begin
        reg_rd = 1; reg_idx = 2'($urandom);
      end
      ev_done  = ($urandom % 5 == 0);
      ev_col   = ($urandom % 23 == 0);
      ev_retry = ($urandom % 29 == 0);
      ev_under = ($urandom % 19 == 0);
      tick();
    end
    quiet();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule